// File: doc/BRIEF.md
# Multi-Mode Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter with eight multiplexed inputs. For each conversion it chooses an input channel, gives the sample-and-hold one sample cycle, and then runs a binary search. During the search it drives a trial code to the DAC and reads back one comparator bit per cycle. Each finished code goes into a result register owned by that channel. Software reads any of these registers through a channel-indexed read port.

A start pulse launches the selected operating mode, and the mode is latched at that moment. There are six modes:

| Code | Mode | Behaviour |
|------|------|-----------|
| 0 | Fixed single | One conversion on channel A |
| 1 | Fixed repeat | Repeats channel A |
| 2 | Scan once | Walks the enabled channels in rising index order, one pass |
| 3 | Scan repeat | Same walk, endless |
| 4 | Ping-pong | Alternates channel A and channel B |
| 5 | Step | One conversion on channel A per start |

A stop pulse lets the conversion in progress finish and then halts. A sticky completion flag acts as the interrupt source and is cleared by writing a one.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `busy`, `done_irq` and `sh_pulse` are 0, `dac_code` is 0, and every result register reads 0. Whenever `busy` is 0, `dac_code` is 0.
- R2: A conversion tries the bits MSB first. Each trial cycle drives `dac_code` as the bits kept so far plus the bit under test. The bit is kept when `cmp_in` is 1, meaning the held input is at or above `dac_code`. With an ideal comparator the stored result equals the input code for every value 0 to 1023.
- R3: Each conversion is one cycle with `sh_pulse` high and `mux_sel` on the chosen channel, followed by 10 trial cycles. The first trial drives `dac_code` = 0x200, and `mux_sel` stays unchanged across the conversion. A single conversion therefore keeps `busy` high for 11 cycles, and back-to-back conversions start every 11 cycles.
- R4: `cfg_mode` = 0 (fixed single) makes exactly one conversion on `sel_a`, then goes idle.
- R5: `cfg_mode` = 1 (fixed repeat) converts `sel_a` again and again until stopped.
- R6: `cfg_mode` = 2 (scan once) converts every channel whose `ch_enable` bit is 1, in rising index order, and then stops. `done_irq` is not set before the pass ends.
- R7: `cfg_mode` = 3 (scan repeat) works like scan once, but goes back to the lowest enabled channel after the highest one, until stopped.
- R8: `cfg_mode` = 4 (ping-pong) converts `sel_a`, then `sel_b`, alternating, until stopped.
- R9: `cfg_mode` = 5 (step) makes exactly one conversion on `sel_a` for each accepted start.
- R10: `done_irq` is set when a conversion ends in modes 0, 1, 4 and 5, and when a scan pass ends in modes 2 and 3. A one-cycle pulse on `done_clr` clears it.
- R11: A stop pulse during a run lets the current conversion finish and starts no further conversion.
- R12: A start is ignored when `ch_enable` is all zero, and ignored while `busy` is high.
- R13: `rd_data` shows the result register of the channel on `rd_ch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_mode | input | 3 | Operating mode code (0..5), latched at start |
| ch_enable | input | 8 | Channel enable mask; also gates start |
| sel_a | input | 3 | Channel A for fixed, step and ping-pong modes |
| sel_b | input | 3 | Channel B for ping-pong mode |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| done_clr | input | 1 | Write-one clear of the completion flag |
| rd_ch | input | 3 | Result readback channel |
| rd_data | output | 10 | Result of channel `rd_ch` |
| busy | output | 1 | A run is in progress |
| done_irq | output | 1 | Sticky completion flag |
| mux_sel | output | 3 | Input multiplexer channel |
| sh_pulse | output | 1 | Sample-and-hold strobe |
| dac_code | output | 10 | DAC trial code |
| cmp_in | input | 1 | Comparator: 1 when held input >= DAC level |

## Verification
The hardest states to reach from the ports are the run endings: a stop that lands inside a later conversion of a repeating mode, a scan that wraps around, and a start that arrives while a conversion is running. The bench places each stop pulse a counted number of cycles after start, so the exact number and order of conversions is known in advance. It then compares these with a log of every sample strobe. A sweep over all 1024 input codes in step mode covers every search path of the bit trial.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    MODE_FIX_ONE   = 3'd0,
    MODE_FIX_LOOP  = 3'd1,
    MODE_SCAN_ONE  = 3'd2,
    MODE_SCAN_LOOP = 3'd3,
    MODE_DUAL      = 3'd4,
    MODE_STEP      = 3'd5
  } seq_mode_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SAMP  = 2'd1,
    ENG_TRIAL = 2'd2
  } eng_state_e;
endpackage

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic [2:0]      mode,
  input  logic [CH_W-1:0] cur,
  input  logic [CH_W-1:0] sel_a,
  input  logic [CH_W-1:0] sel_b,
  input  logic [N_CH-1:0] en,
  output logic [CH_W-1:0] first_ch,
  output logic [CH_W-1:0] next_ch,
  output logic            pass_end
);
  logic [CH_W-1:0] low_ch, hi_ch;
  logic            hi_ok;

  // lowest enabled channel and lowest enabled channel above cur
  always_comb begin
    low_ch = '0;
    hi_ch  = '0;
    hi_ok  = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (en[i]) low_ch = CH_W'(i);
      if (en[i] && (i > int'(cur))) begin
        hi_ch = CH_W'(i);
        hi_ok = 1'b1;
      end
    end
  end

  always_comb begin
    first_ch = sel_a;
    next_ch  = sel_a;
    pass_end = 1'b1;
    case (mode)
      MODE_SCAN_ONE, MODE_SCAN_LOOP: begin
        first_ch = low_ch;
        next_ch  = hi_ok ? hi_ch : low_ch;
        pass_end = ~hi_ok;
      end
      MODE_DUAL: begin
        next_ch = (cur == sel_a) ? sel_b : sel_a;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CH_W-1:0]  go_ch,
  input  logic             cmp_in,
  output logic             sh_pulse,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  mux_sel,
  output logic             conv_last,
  output logic [RES_W-1:0] conv_result
);
  localparam int BW = $clog2(RES_W);

  eng_state_e       st_q, st_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [RES_W-1:0] code_q, code_d, kept;
  logic [CH_W-1:0]  ch_q;
  logic             ch_en;

  assign sh_pulse    = (st_q == ENG_SAMP);
  assign mux_sel     = ch_q;
  assign dac_code    = (st_q == ENG_TRIAL) ? (code_q | (RES_W'(1) << bit_q)) : '0;
  assign kept        = cmp_in ? dac_code : code_q;
  assign conv_last   = (st_q == ENG_TRIAL) && (bit_q == '0);
  assign conv_result = kept;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    code_d = code_q;
    ch_en  = 1'b0;
    case (st_q)
      ENG_IDLE: if (go) begin
        st_d  = ENG_SAMP;
        ch_en = 1'b1;
      end
      ENG_SAMP: begin
        st_d   = ENG_TRIAL;
        bit_d  = BW'(RES_W - 1);
        code_d = '0;
      end
      ENG_TRIAL: begin
        code_d = kept;
        if (bit_q == '0) begin
          st_d  = go ? ENG_SAMP : ENG_IDLE;
          ch_en = go;
        end else begin
          bit_d = bit_q - 1'b1;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      bit_q  <= '0;
      code_q <= '0;
      ch_q   <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      code_q <= code_d;
      if (ch_en) ch_q <= go_ch;
    end
  end
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank #(
  parameter int RES_W = 10,
  parameter int N_CH  = 8,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [RES_W-1:0] wr_data,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data
);
  logic [RES_W-1:0] regs_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (wr_en && (wr_ch == CH_W'(g))) regs_q[g] <= wr_data;
    end
  end

  assign rd_data = regs_q[rd_ch];
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int N_CH  = 8,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode,
  input  logic [N_CH-1:0]  ch_enable,
  input  logic [CH_W-1:0]  sel_a,
  input  logic [CH_W-1:0]  sel_b,
  input  logic             start,
  input  logic             stop,
  input  logic             done_clr,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic             busy,
  output logic             done_irq,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sh_pulse,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [2:0]       mode_q, mode_eff;
  logic             run_q, run_d, stop_q, stop_d, done_q, done_d;
  logic             start_ok, keep_going, done_set, go, is_scan, repeats;
  logic [CH_W-1:0]  first_ch, next_ch, go_ch;
  logic             pass_end, conv_last;
  logic [RES_W-1:0] conv_result;

  assign mode_eff = run_q ? mode_q : cfg_mode;

  adc_seq_chsel #(.N_CH(N_CH), .CH_W(CH_W)) chsel_i (
    .mode(mode_eff), .cur(mux_sel), .sel_a(sel_a), .sel_b(sel_b),
    .en(ch_enable), .first_ch(first_ch), .next_ch(next_ch), .pass_end(pass_end)
  );

  adc_seq_sar #(.RES_W(RES_W), .CH_W(CH_W)) sar_i (
    .clk(clk), .rst_n(rst_int_n), .go(go), .go_ch(go_ch), .cmp_in(cmp_in),
    .sh_pulse(sh_pulse), .dac_code(dac_code), .mux_sel(mux_sel),
    .conv_last(conv_last), .conv_result(conv_result)
  );

  adc_seq_bank #(.RES_W(RES_W), .N_CH(N_CH), .CH_W(CH_W)) bank_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(conv_last), .wr_ch(mux_sel),
    .wr_data(conv_result), .rd_ch(rd_ch), .rd_data(rd_data)
  );

  // run control
  always_comb begin
    is_scan    = (mode_q == MODE_SCAN_ONE) || (mode_q == MODE_SCAN_LOOP);
    repeats    = (mode_q == MODE_FIX_LOOP) || (mode_q == MODE_SCAN_LOOP) ||
                 (mode_q == MODE_DUAL) || ((mode_q == MODE_SCAN_ONE) && !pass_end);
    start_ok   = !run_q && start && (ch_enable != '0);
    keep_going = conv_last && !stop_q && !stop && repeats;
    go         = start_ok || keep_going;
    go_ch      = start_ok ? first_ch : next_ch;
    done_set   = conv_last && (!is_scan || pass_end);

    run_d = run_q;
    if (start_ok) run_d = 1'b1;
    else if (conv_last && !keep_going) run_d = 1'b0;

    stop_d = stop_q;
    if (start_ok) stop_d = 1'b0;
    else if (run_q && stop) stop_d = 1'b1;

    done_d = done_q;
    if (done_set) done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= 3'd0;
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_ok) mode_q <= cfg_mode;
      run_q  <= run_d;
      stop_q <= stop_d;
      done_q <= done_d;
    end
  end

  assign busy     = run_q;
  assign done_irq = done_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int N_CH  = 8,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [N_CH-1:0]  ch_enable,
  input logic             busy,
  input logic             done_irq,
  input logic             sh_pulse,
  input logic [RES_W-1:0] dac_code,
  input logic [CH_W-1:0]  mux_sel
);
  p_idle_dac_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

  p_sample_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_pulse |=> !sh_pulse);

  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_pulse |=> (dac_code == (RES_W'(1) << (RES_W - 1))));

  p_mux_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_pulse |=> $stable(mux_sel));

  p_done_from_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) |-> $past(busy));

  p_empty_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (ch_enable == '0)) |=> !busy);
endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W), .N_CH(N_CH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ch_enable(ch_enable), .busy(busy),
  .done_irq(done_irq), .sh_pulse(sh_pulse), .dac_code(dac_code), .mux_sel(mux_sel)
);

// File: tb/adc_seq_top_tb_top.sv
`timescale 1ns/1ps
module adc_seq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_mode;
  logic [7:0] ch_enable;
  logic [2:0] sel_a, sel_b, rd_ch;
  logic       start, stop, done_clr;
  logic [9:0] rd_data, dac_code;
  logic       busy, done_irq, sh_pulse, cmp_in;
  logic [2:0] mux_sel;

  always #2 clk = ~clk;

  adc_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ch_enable(ch_enable),
    .sel_a(sel_a), .sel_b(sel_b), .start(start), .stop(stop), .done_clr(done_clr),
    .rd_ch(rd_ch), .rd_data(rd_data), .busy(busy), .done_irq(done_irq),
    .mux_sel(mux_sel), .sh_pulse(sh_pulse), .dac_code(dac_code), .cmp_in(cmp_in)
  );

  // analog model: per-channel level, sample-and-hold, ideal comparator
  logic [9:0] vin [8];
  logic [9:0] held;
  int         nlog;
  logic [2:0] chlog [2048];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      nlog <= 0;
    end else if (sh_pulse) begin
      held <= vin[mux_sel];
      chlog[nlog & 2047] <= mux_sel;
      nlog <= nlog + 1;
    end
  end
  assign cmp_in = (held >= dac_code);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_start(input logic [2:0] m, input logic [7:0] en,
                          input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    cfg_mode = m; ch_enable = en; sel_a = a; sel_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_stop_after(input int n);
    repeat (n) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base, n;
    bit flag;
    rst_n = 1'b0; cfg_mode = '0; ch_enable = '0; sel_a = '0; sel_b = '0;
    start = 0; stop = 0; done_clr = 0; rd_ch = '0;
    for (int c = 0; c < 8; c++) vin[c] = 10'((c * 131 + 17) % 1024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 0 && done_irq == 0 && sh_pulse == 0, "R1", {busy, done_irq, sh_pulse}, 0);
    chk(dac_code == 0, "R1", dac_code, 0);
    for (int c = 0; c < 8; c++) begin
      rd_ch = 3'(c); #1;
      chk(rd_data == 0, "R1", rd_data, 0);
    end

    // R3 timing, R4 fixed single, R10 done
    vin[5] = 10'd700; base = nlog;
    go_start(3'd0, 8'hFF, 3'd5, 3'd0);
    chk(sh_pulse == 1 && mux_sel == 5, "R3", {sh_pulse, mux_sel}, 13);
    n = 1;
    @(negedge clk);
    chk(dac_code == 10'h200, "R3", dac_code, 512);
    n = 2;
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk(n == 11, "R3", n, 11);
    rd_ch = 3'd5; #1;
    chk(rd_data == 700, "R4", rd_data, 700);
    chk(nlog - base == 1, "R4", nlog - base, 1);
    chk(done_irq == 1, "R10", done_irq, 1);
    clr_done();
    chk(done_irq == 0, "R10", done_irq, 0);

    // R2 fixed single on every channel
    for (int c = 0; c < 8; c++) begin
      vin[c] = 10'((c * 293 + 511) % 1024);
      go_start(3'd0, 8'h01, 3'(c), 3'd0);
      wait_idle();
      rd_ch = 3'(c); #1;
      chk(rd_data == vin[c], "R2", rd_data, vin[c]);
    end

    // R2 / R9 exhaustive code sweep in step mode
    for (int v = 0; v < 1024; v++) begin
      vin[4] = 10'(v); base = nlog;
      go_start(3'd5, 8'h10, 3'd4, 3'd0);
      wait_idle();
      rd_ch = 3'd4; #1;
      chk(rd_data == 10'(v), "R2", rd_data, v);
      if (v % 128 == 0) chk(nlog - base == 1, "R9", nlog - base, 1);
    end

    // R12 start while busy ignored (step mode)
    base = nlog;
    go_start(3'd5, 8'h10, 3'd4, 3'd0);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle(); repeat (3) @(negedge clk);
    chk(nlog - base == 1, "R12", nlog - base, 1);

    // R12 start with no channels enabled ignored
    base = nlog;
    go_start(3'd1, 8'h00, 3'd2, 3'd0);
    chk(busy == 0, "R12", busy, 0);
    repeat (4) @(negedge clk);
    chk(nlog - base == 0 && busy == 0, "R12", nlog - base, 0);

    // R5 / R11 fixed repeat, stop inside the 4th conversion
    vin[3] = 10'd321; base = nlog;
    go_start(3'd1, 8'hFF, 3'd3, 3'd0);
    pulse_stop_after(40);
    wait_idle();
    chk(nlog - base == 4, "R11", nlog - base, 4);
    flag = 1;
    for (int k = 0; k < 4; k++) if (chlog[(base + k) & 2047] != 3'd3) flag = 0;
    chk(flag, "R5", flag, 1);
    rd_ch = 3'd3; #1;
    chk(rd_data == 321, "R5", rd_data, 321);

    // R6 scan once over channels 1,2,5,7
    clr_done();
    base = nlog; flag = 1;
    go_start(3'd2, 8'b1010_0110, 3'd0, 3'd0);
    while (busy) begin if (done_irq) flag = 0; @(negedge clk); end
    chk(flag, "R6", flag, 1);
    chk(done_irq == 1, "R6", done_irq, 1);
    chk(nlog - base == 4, "R6", nlog - base, 4);
    chk(chlog[base & 2047] == 1 && chlog[(base + 1) & 2047] == 2 &&
        chlog[(base + 2) & 2047] == 5 && chlog[(base + 3) & 2047] == 7,
        "R6", chlog[(base + 3) & 2047], 7);

    // R7 scan repeat over channels 0,7, stop in the 5th conversion
    base = nlog;
    go_start(3'd3, 8'b1000_0001, 3'd0, 3'd0);
    pulse_stop_after(50);
    wait_idle();
    chk(nlog - base == 5, "R7", nlog - base, 5);
    flag = 1;
    for (int k = 0; k < 5; k++)
      if (chlog[(base + k) & 2047] != ((k % 2 == 0) ? 3'd0 : 3'd7)) flag = 0;
    chk(flag, "R7", flag, 1);

    // R8 ping-pong between 6 and 2, stop in the 3rd conversion
    base = nlog;
    go_start(3'd4, 8'hFF, 3'd6, 3'd2);
    pulse_stop_after(30);
    wait_idle();
    chk(nlog - base == 3, "R8", nlog - base, 3);
    chk(chlog[base & 2047] == 6 && chlog[(base + 1) & 2047] == 2 &&
        chlog[(base + 2) & 2047] == 6, "R8", chlog[(base + 1) & 2047], 2);

    // R13 readback of every channel after a full scan
    for (int c = 0; c < 8; c++) vin[c] = 10'((c * 97 + 300) % 1024);
    go_start(3'd2, 8'hFF, 3'd0, 3'd0);
    wait_idle();
    for (int c = 0; c < 8; c++) begin
      rd_ch = 3'(c); #1;
      chk(rd_data == vin[c], "R13", rd_data, vin[c]);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule